// File: doc/BRIEF.md
# Adaptive Quadrature Imbalance Corrector

This block sits in a zero-IF receive path and repairs the mismatch between the in-phase (I) and quadrature (Q) branches. A gain mismatch or a phase skew between the branches makes each tone leave a mirror image on the other side of DC. The block estimates both errors blindly from the signal it is passing. It needs no pilot or training sequence. It then applies one gain term and one phase term across the whole band. The I branch passes through unchanged. The Q branch is rewritten as `Q' = (1 + dg)·(Q − p·I)`.

The two estimates are built by feedback from the corrected output. The phase term follows the sign of a leaky running mean of `I·Q'`. The gain term follows the sign of a leaky running mean of `|I| − |Q'|`. On each valid sample that is not frozen, each term moves by a step of `2^-k` of one coefficient LSB, where `k` is set by `mu_shift`. Each loop has its own enable bit and its own freeze bit in a four-bit control word. After reset both enables are low, so samples flow through untouched.

Top module: `iqc_corrector`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_valid`, `out_i` and `out_q` are all zero.
- R2: `out_valid` follows `in_valid` with a delay of exactly three clock cycles. A sample accepted at clock edge n appears on the outputs after edge n+3.
- R3: When both enable bits are low (`ctrl[0]` gain enable, `ctrl[1]` phase enable; both low after reset), `out_i` and `out_q` are exact copies of the inputs from three cycles earlier.
- R4: The corrected Q is computed as follows.
  - Define `rnd(x) = (x + 2^14) >>> 15`.
  - Compute `t = sat(Q − rnd(p·I))`.
  - Compute `Q' = sat(t + rnd(dg·t))`.
  - Here p and dg are signed Q1.15 values and `sat` clamps to the signed 16-bit range.
  - I is output unchanged.
- R5: The gain delta dg never leaves the range [−3899, +3998] LSB of 2^-15. This is about −1.1 dB to +1.0 dB. A larger mismatch leaves dg held at the bound.
- R6: The phase term p never leaves the range [−1023, +1023] LSB of 2^-15. This is about ±1.79 degrees. A larger skew leaves p held at the bound.
- R7: A loop whose enable bit is low applies a zero term. Its stored estimate is kept as long as the other loop is enabled.
- R8: While a loop's freeze bit is set (`ctrl[2]` gain, `ctrl[3]` phase), its estimate does not change, whatever the input. The frozen estimate is still applied.
- R9: When both enable bits are low, both stored estimates are cleared to zero. While either enable bit is high, the estimates are kept.
- R10: With both loops enabled and `mu_shift` = 3, take a single tone carrying a 0.9 gain error and a 1.2 degree phase error. After 50000 samples, the image-to-tone power ratio is at least 20 dB below its uncorrected value.
- R11: When the correction pushes Q' beyond the 16-bit range, Q' saturates at +32767 or −32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input, signed |
| in_q | input | 16 | Quadrature input, signed |
| ctrl | input | 4 | [0] gain enable, [1] phase enable, [2] gain freeze, [3] phase freeze |
| mu_shift | input | 4 | Adaptation step exponent k (step = 2^-k LSB per sample) |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | In-phase output, signed |
| out_q | output | 16 | Corrected quadrature output, signed |

## Verification
Every corrected sample is due three cycles after it is accepted. The bench therefore keeps a three-deep queue of expected strobe and data values, computed when each input is driven. It compares the head of that queue on the third falling edge after the drive. Checking is done only after the control word has been held over a flushed pipeline, so in-flight samples never see two different settings. Convergence is judged on the image ratio over 4096 output samples taken after the adaptation run. Clamp, freeze, retention and clearing are all observed through exact output values, with both loops frozen.

// File: rtl/iqc_pkg.sv
// Package: shared control-word layout and loop indices for the I/Q corrector.
// Assumes a four-bit control word with enables in the low bits.
package iqc_pkg;
    typedef struct packed {
        logic phase_frz;
        logic gain_frz;
        logic phase_en;
        logic gain_en;
    } iqc_ctrl_t;

    localparam int NUM_LOOPS  = 2;
    localparam int LOOP_GAIN  = 0;
    localparam int LOOP_PHASE = 1;
endpackage

// File: rtl/iqc_apply.sv
// Three-stage correction datapath.
// Stage 1 registers the sample and forms p*I. Stage 2 removes the rounded
// cross term from Q. Stage 3 scales the result by (1 + dg).
// I is only delayed. Assumes the coefficients are Q1.15 with CW-1
// fractional bits and that the caller holds them steady while it needs
// exact results.
module iqc_apply #(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic signed [CW-1:0] p_app,
    input  logic signed [CW-1:0] g_app,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    localparam int FR = CW - 1;
    localparam int PW = W + CW;
    localparam int SW = PW + 1;
    localparam logic signed [PW-1:0] HALF = {{(PW-FR){1'b0}}, 1'b1, {(FR-1){1'b0}}};
    localparam logic signed [W-1:0]  WMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0]  WMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [SW-1:0] XMAX = SW'(WMAX);
    localparam logic signed [SW-1:0] XMIN = SW'(WMIN);

    // Round a Q1.15 product back to sample scale.
    function automatic logic signed [PW-1:0] rnd(input logic signed [PW-1:0] x);
        return (x + HALF) >>> FR;
    endfunction

    // Clamp a widened sum into the sample range.
    function automatic logic signed [W-1:0] sat_w(input logic signed [SW-1:0] x);
        if (x > XMAX)      return WMAX;
        else if (x < XMIN) return WMIN;
        else               return x[W-1:0];
    endfunction

    logic                v1, v2;
    logic signed [W-1:0] i1, q1, i2, t2;
    logic signed [PW-1:0] pi1;
    logic signed [PW-1:0] gt2;
    logic signed [SW-1:0] diff2, sum3;

    // Cross-term subtraction and gain-product width fitting.
    always_comb begin
        diff2 = SW'(q1) - SW'(rnd(pi1));
        gt2   = g_app * t2;
        sum3  = SW'(t2) + SW'(rnd(gt2));
    end

    // Pipeline registers for all three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; i1 <= '0; q1 <= '0; pi1 <= '0;
            v2 <= 1'b0; i2 <= '0; t2 <= '0;
            out_valid <= 1'b0; out_i <= '0; out_q <= '0;
        end else begin
            v1  <= in_valid;
            i1  <= in_i;
            q1  <= in_q;
            pi1 <= p_app * in_i;
            v2  <= v1;
            i2  <= i1;
            t2  <= sat_w(diff2);
            out_valid <= v2;
            out_i     <= i2;
            out_q     <= sat_w(sum3);
        end
    end
endmodule

// File: rtl/iqc_track.sv
// One sign-driven adaptation loop.
// A leaky accumulator keeps 2^MSH times the running mean of the error.
// The coefficient, carried with FRAC extra fraction bits, moves one step
// of 2^-k LSB toward the sign of that mean and is clamped to [CMIN, CMAX].
// Assumes a positive mean calls for a larger coefficient.
module iqc_track #(
    parameter int EW   = 32,
    parameter int CW   = 16,
    parameter int FRAC = 15,
    parameter int SHW  = 4,
    parameter int MSH  = 8,
    parameter int CMIN = -1023,
    parameter int CMAX = 1023
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid,
    input  logic signed [EW-1:0] err,
    input  logic                 en,
    input  logic                 frz,
    input  logic                 clr,
    input  logic [SHW-1:0]       k,
    output logic signed [CW-1:0] coef
);
    localparam int AW = EW + MSH + 1;
    localparam int FW = CW + FRAC;
    localparam logic signed [FW+1:0] LO = (FW+2)'(CMIN) <<< FRAC;
    localparam logic signed [FW+1:0] HI = (FW+2)'(CMAX) <<< FRAC;

    logic signed [AW-1:0] acc;
    logic signed [FW-1:0] fine, fine_nxt;
    logic [FW:0]          step_u;
    logic signed [FW+1:0] f_ext, s_ext, cand;

    // Next coefficient: signed step toward the mean, then clamp.
    always_comb begin
        step_u = ({{FW{1'b0}}, 1'b1} << FRAC) >> k;
        f_ext  = (FW+2)'(fine);
        s_ext  = $signed({1'b0, step_u});
        if (acc > 0)      cand = f_ext + s_ext;
        else if (acc < 0) cand = f_ext - s_ext;
        else              cand = f_ext;
        if (cand < LO)      fine_nxt = LO[FW-1:0];
        else if (cand > HI) fine_nxt = HI[FW-1:0];
        else                fine_nxt = cand[FW-1:0];
    end

    // Accumulator and coefficient state; clear wins, freeze holds.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc  <= '0;
            fine <= '0;
        end else if (en && !frz && upd_valid) begin
            acc  <= acc - (acc >>> MSH) + AW'(err);
            fine <= fine_nxt;
        end
    end

    assign coef = fine[FW-1:FRAC];

    // R5 and R6: the applied term stays inside its correction range.
    a_r5_r6_coef_range: assert property (@(posedge clk) disable iff (!rst_n)
        (coef >= CMIN) && (coef <= CMAX));

    // R8: a frozen, enabled loop keeps its estimate.
    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && frz && !clr) |=> $stable(fine));

    // R9: with both loops disabled the state is wiped.
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fine == '0) && (acc == '0));
endmodule

// File: rtl/iqc_corrector.sv
// Top of the adaptive I/Q imbalance corrector.
// It decodes the control word, forms the blind error terms from the
// corrected output, runs one tracking loop per error (gain, phase) and
// applies the enabled terms in the three-stage datapath.
// Assumes the ctrl bit layout given in iqc_pkg.
module iqc_corrector #(
    parameter int W         = 16,
    parameter int CW        = 16,
    parameter int FRAC      = 15,
    parameter int SHW       = 4,
    parameter int MSH       = 8,
    parameter int GAIN_MIN  = -3899,
    parameter int GAIN_MAX  = 3998,
    parameter int PHASE_MIN = -1023,
    parameter int PHASE_MAX = 1023
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_i,
    input  logic signed [W-1:0]  in_q,
    input  logic [3:0]           ctrl,
    input  logic [SHW-1:0]       mu_shift,
    output logic                 out_valid,
    output logic signed [W-1:0]  out_i,
    output logic signed [W-1:0]  out_q
);
    import iqc_pkg::*;

    localparam int EW = 2 * W;

    iqc_ctrl_t            cw;
    logic                 clr;
    logic signed [W:0]    abs_i, abs_q;
    logic signed [EW-1:0] err_arr [NUM_LOOPS];
    logic                 en_arr  [NUM_LOOPS];
    logic                 frz_arr [NUM_LOOPS];
    logic signed [CW-1:0] coef_arr[NUM_LOOPS];
    logic signed [CW-1:0] p_app, g_app;

    // Decode control and build the blind error terms from the output.
    always_comb begin
        cw    = iqc_ctrl_t'(ctrl);
        clr   = !(cw.gain_en || cw.phase_en);
        abs_i = out_i[W-1] ? -(W+1)'(out_i) : (W+1)'(out_i);
        abs_q = out_q[W-1] ? -(W+1)'(out_q) : (W+1)'(out_q);
        err_arr[LOOP_GAIN]  = EW'(abs_i - abs_q);
        err_arr[LOOP_PHASE] = out_i * out_q;
        en_arr[LOOP_GAIN]   = cw.gain_en;
        en_arr[LOOP_PHASE]  = cw.phase_en;
        frz_arr[LOOP_GAIN]  = cw.gain_frz;
        frz_arr[LOOP_PHASE] = cw.phase_frz;
        g_app = cw.gain_en  ? coef_arr[LOOP_GAIN]  : '0;
        p_app = cw.phase_en ? coef_arr[LOOP_PHASE] : '0;
    end

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        localparam int LMIN = (g == LOOP_GAIN) ? GAIN_MIN : PHASE_MIN;
        localparam int LMAX = (g == LOOP_GAIN) ? GAIN_MAX : PHASE_MAX;
        iqc_track #(
            .EW(EW), .CW(CW), .FRAC(FRAC), .SHW(SHW), .MSH(MSH),
            .CMIN(LMIN), .CMAX(LMAX)
        ) u_trk (
            .clk(clk), .rst_n(rst_n), .upd_valid(out_valid),
            .err(err_arr[g]), .en(en_arr[g]), .frz(frz_arr[g]),
            .clr(clr), .k(mu_shift), .coef(coef_arr[g])
        );
    end

    iqc_apply #(.W(W), .CW(CW)) u_apply (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .p_app(p_app), .g_app(g_app),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    logic [1:0] age;
    logic [1:0] off_cnt;

    // Cycles since reset and cycles with both loops off, both saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age     <= '0;
            off_cnt <= '0;
        end else begin
            if (age != 2'd3) age <= age + 2'd1;
            if (clr) off_cnt <= (off_cnt == 2'd3) ? off_cnt : off_cnt + 2'd1;
            else     off_cnt <= '0;
        end
    end

    // R2: the output strobe is the input strobe three cycles late.
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3: with both loops off for the whole flight, data is unchanged.
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (off_cnt == 2'd3 && out_valid) |->
        (out_i == $past(in_i, 3)) && (out_q == $past(in_q, 3)));
endmodule

// File: tb/sim_iqc_corrector.sv
// Bench for iqc_corrector: random and directed samples checked against a
// bench model of the correction formula, plus an image-ratio measurement
// on a single impaired tone.
module sim_iqc_corrector;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic signed [15:0] in_i, in_q;
    logic [3:0]         ctrl;
    logic [3:0]         mu;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    always #10 clk = ~clk;

    iqc_corrector u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .ctrl(ctrl), .mu_shift(mu), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    localparam int  NMEAS = 4096;
    localparam real TWO_PI = 6.283185307179586;

    int    total = 0, bad = 0;
    string cur_req = "R3";
    int    mdl_p = 0, mdl_g = 0;
    bit    chk_on = 0;
    bit    pv[3], pc[3];
    int    pi_[3], pq_[3];
    int    tn = 0;
    bit    meas = 0;
    int    meas_n = 0;
    real   pr, pim, nr, nim;

    function automatic int sat16(longint x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    function automatic longint rnd15(longint x);
        return (x + 64'sd16384) >>> 15;
    endfunction

    // Expected Q' per R4 with saturation per R11.
    function automatic int exp_q(int i, int q, int p, int g);
        longint t;
        t = sat16(longint'(q) - rnd15(longint'(p) * i));
        return sat16(t + rnd15(longint'(g) * t));
    endfunction

    task automatic check(string req, bit ok, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock: check the sample due now, record image sums, drive the next.
    task automatic step(bit v, int i, int q);
        real th;
        @(negedge clk);
        if (pc[2]) begin
            check("R2", out_valid == pv[2], int'(out_valid), int'(pv[2]));
            if (pv[2] && out_valid) begin
                check(cur_req, out_i == pi_[2], int'(out_i), pi_[2]);
                check(cur_req, out_q == pq_[2], int'(out_q), pq_[2]);
            end
        end
        if (meas && out_valid && meas_n < NMEAS) begin
            th  = TWO_PI * real'(meas_n % 16) / 16.0;
            pr  += real'(out_i) * $cos(th) + real'(out_q) * $sin(th);
            pim += real'(out_q) * $cos(th) - real'(out_i) * $sin(th);
            nr  += real'(out_i) * $cos(th) - real'(out_q) * $sin(th);
            nim += real'(out_q) * $cos(th) + real'(out_i) * $sin(th);
            meas_n++;
        end
        for (int s = 2; s > 0; s--) begin
            pv[s] = pv[s-1]; pc[s] = pc[s-1]; pi_[s] = pi_[s-1]; pq_[s] = pq_[s-1];
        end
        pv[0] = v; pc[0] = chk_on; pi_[0] = i; pq_[0] = exp_q(i, q, mdl_p, mdl_g);
        in_valid = v; in_i = 16'(i); in_q = 16'(q);
    endtask

    // Flush the pipe, change control and model, settle.
    task automatic set_ctrl(logic [3:0] c, int p, int g, bit chk, string req);
        repeat (4) step(1'b0, 0, 0);
        ctrl = c; mdl_p = p; mdl_g = g; chk_on = chk; cur_req = req;
        repeat (2) step(1'b0, 0, 0);
    endtask

    function automatic int pick();
        int r;
        r = int'($urandom_range(0, 9));
        if (r == 0) return 32767;
        if (r == 1) return -32768;
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic rand_run(int n);
        for (int s = 0; s < n; s++) step($urandom_range(0, 3) != 0, pick(), pick());
    endtask

    // Continuous tone at +fs/16 with the given Q gain and phase error.
    task automatic tone(int n, real a, real g, real phdeg);
        real th, ph;
        ph = phdeg * TWO_PI / 360.0;
        for (int s = 0; s < n; s++) begin
            th = TWO_PI * real'(tn % 16) / 16.0;
            step(1'b1, int'(a * $cos(th)), int'(a * g * $sin(th + ph)));
            tn++;
        end
    endtask

    task automatic measure(real a, real g, real phdeg, output real ratio);
        pr = 0.0; pim = 0.0; nr = 0.0; nim = 0.0; meas_n = 0; meas = 1;
        tone(NMEAS + 4, a, g, phdeg);
        meas = 0;
        ratio = (nr * nr + nim * nim) / (pr * pr + pim * pim);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        real r0, r1;
        void'($urandom(32'd7321));
        for (int s = 0; s < 3; s++) begin pv[s] = 0; pc[s] = 0; pi_[s] = 0; pq_[s] = 0; end
        rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; ctrl = 4'h0; mu = 4'd3;
        repeat (5) @(negedge clk);
        // R1: reset state.
        check("R1", out_valid == 1'b0, int'(out_valid), 0);
        check("R1", out_i == 0, int'(out_i), 0);
        check("R1", out_q == 0, int'(out_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", out_valid == 1'b0 && out_q == 0, int'(out_q), 0);

        // R3 and R2: default pass-through of random and extreme samples.
        chk_on = 1; cur_req = "R3";
        rand_run(1500);

        // R10: baseline image, then adapt both loops and measure again.
        measure(20000.0, 0.9, 1.2, r0);
        check("R10", r0 > 1.0e-3, int'(r0 * 1.0e6), 1000);
        set_ctrl(4'b0011, 0, 0, 1'b0, "R10");
        tone(50000, 20000.0, 0.9, 1.2);
        measure(20000.0, 0.9, 1.2, r1);
        $display("image ratio before %e after %e", r0, r1);
        check("R10", r1 * 100.0 <= r0, int'(r1 * 1.0e9), int'(r0 * 1.0e7));

        // R5: clear, adapt gain only against a half-size Q, then freeze.
        mu = 4'd0;
        set_ctrl(4'b0000, 0, 0, 1'b0, "R9");
        set_ctrl(4'b0001, 0, 0, 1'b0, "R5");
        tone(12000, 16000.0, 0.5, 0.0);
        set_ctrl(4'b0101, 0, 3998, 1'b1, "R5");
        rand_run(500);

        // R6: adapt phase against a 10 degree skew with gain frozen, then freeze.
        set_ctrl(4'b0111, 0, 3998, 1'b0, "R6");
        tone(6000, 16000.0, 1.0, 10.0);
        set_ctrl(4'b1111, 1023, 3998, 1'b1, "R6");
        rand_run(500);

        // R8: both frozen; opposite errors must not move either term.
        cur_req = "R8";
        tone(3000, 16000.0, 1.3, -10.0);
        rand_run(500);

        // R11: directed saturation with both terms at their upper bounds.
        cur_req = "R11";
        step(1'b1, 0, 32767);
        step(1'b1, 0, -32768);
        step(1'b1, -32768, 32767);
        step(1'b1, 32767, -32768);
        step(1'b1, 1000, 31000);

        // R7: gain disabled applies zero while phase stays in force.
        set_ctrl(4'b1010, 1023, 0, 1'b1, "R7");
        rand_run(300);

        // R9: gain re-enabled still holds its old estimate.
        set_ctrl(4'b1111, 1023, 3998, 1'b1, "R9");
        rand_run(300);

        // R9: both off clears; re-enabled frozen loops apply zero.
        set_ctrl(4'b0000, 0, 0, 1'b1, "R9");
        set_ctrl(4'b1111, 0, 0, 1'b1, "R9");
        rand_run(300);

        repeat (4) step(1'b0, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule